// File: doc/BRIEF.md
# Even/Odd Receive Stream Splitter

This block sits on a receive sample path and sorts each incoming sample into a substream by its position within the current line. When splitting is on, samples take turns between an even substream and an odd substream. An optional second level divides the odd substream again, into odd-A and odd-B, which take turns. Each sample leaves on one of two valid/ready output channels. It carries a two-bit tag that names its substream, and its data is passed through unchanged.

Routing is combinational and adds no register stage. A sample that is offered is presented on its target channel in the same cycle. The input ready is the ready of that channel. A per-line restart flag travels with the first sample of each line and forces that sample to be even. Packing and width conversion are not part of this block: data is neither packed nor padded in any mode.

Top module: `stream_splitter`

## Requirements
- R1: After reset, both output valids are low while no sample is offered, and the first sample accepted after reset is classed even.
- R2: With split disabled, every sample goes to channel 0 with tag 0 (pass), and channel 1 never asserts valid.
- R3: With split enabled and subsplit off, accepted samples alternate even (tag 1), odd (tag 2), starting from even.
- R4: With split and subsplit enabled, accepted samples repeat the order even (tag 1), odd-A (tag 2), even (tag 1), odd-B (tag 3).
- R5: With split enabled and two-channel mode set, even samples leave on channel 0 and all odd samples (odd, odd-A, odd-B) leave on channel 1.
- R6: With split enabled and two-channel mode clear, every substream leaves on channel 0 in arrival order with its own tag, and channel 1 stays idle.
- R7: A sample offered with the line-start flag high is classed even, and the order of R3/R4 restarts from it.
- R8: The input ready equals the ready of the channel that the current sample targets, and the position advances only on an accepted sample, so a stalled sample keeps its class.
- R9: The subsplit and two-channel settings have no effect while split is disabled.
- R10: Output data equals the input data bit for bit in every mode, and at most one output valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with valid |
| in_data | input | DATA_W | Input sample |
| in_line_start | input | 1 | Sample is the first of a line |
| cfg_split | input | 1 | Enable even/odd split |
| cfg_odd_sub | input | 1 | Split the odd substream again |
| cfg_two_ch | input | 1 | Route odd substreams to channel 1 |
| ch0_valid | output | 1 | Channel 0 valid |
| ch0_ready | input | 1 | Channel 0 ready |
| ch0_data | output | DATA_W | Channel 0 data |
| ch0_tag | output | 2 | Channel 0 substream tag (0 pass, 1 even, 2 odd/odd-A, 3 odd-B) |
| ch1_valid | output | 1 | Channel 1 valid |
| ch1_ready | input | 1 | Channel 1 ready |
| ch1_data | output | DATA_W | Channel 1 data |
| ch1_tag | output | 2 | Channel 1 substream tag |

## Verification
A line restart and a stall on the target channel can land on the same cycle. When they do, the restart must class the held sample as even, and the position must stay frozen until that sample is accepted. The random phase raises the line-start flag and drops each channel's ready on independent draws, so this overlap occurs many times. A reference model kept in the bench judges each cycle: it follows the position only on handshakes and predicts the channel, tag, data and input ready.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
   typedef enum logic [1:0] {
      TAG_PASS  = 2'd0,
      TAG_EVEN  = 2'd1,
      TAG_ODD_A = 2'd2,
      TAG_ODD_B = 2'd3
   } sub_tag_e;

   localparam int unsigned POS_W = 2;
endpackage

// File: rtl/split_phase.sv
module split_phase
   import splitter_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             advance,
   output logic [POS_W-1:0] cur_pos
);
   logic [POS_W-1:0] pos_q;

   // a line start forces the current sample back to position zero
   assign cur_pos = restart ? '0 : pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pos_q <= '0;
      else if (advance)
         pos_q <= cur_pos + 1'b1;
   end
endmodule

// File: rtl/split_route.sv
module split_route
   import splitter_pkg::*;
#(
   parameter bit ALLOW_SUBSPLIT = 1'b1
) (
   input  logic             in_valid,
   input  logic [POS_W-1:0] cur_pos,
   input  logic             cfg_split,
   input  logic             cfg_odd_sub,
   input  logic             cfg_two_ch,
   input  logic             ch0_ready,
   input  logic             ch1_ready,
   output logic             ch0_valid,
   output logic             ch1_valid,
   output sub_tag_e         tag,
   output logic             in_ready
);
   logic sub_eff;
   logic to_ch1;

   generate
      if (ALLOW_SUBSPLIT) begin : g_sub
         assign sub_eff = cfg_odd_sub;
      end else begin : g_nosub
         assign sub_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!cfg_split)
         tag = TAG_PASS;
      else if (!cur_pos[0])
         tag = TAG_EVEN;
      else if (sub_eff && cur_pos[1])
         tag = TAG_ODD_B;
      else
         tag = TAG_ODD_A;
   end

   assign to_ch1    = cfg_split && cfg_two_ch && (tag != TAG_EVEN);
   assign ch0_valid = in_valid && !to_ch1;
   assign ch1_valid = in_valid && to_ch1;
   assign in_ready  = to_ch1 ? ch1_ready : ch0_ready;
endmodule

// File: rtl/stream_splitter.sv
module stream_splitter
   import splitter_pkg::*;
#(
   parameter int unsigned DATA_W         = 16,
   parameter bit          ALLOW_SUBSPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_line_start,
   input  logic              cfg_split,
   input  logic              cfg_odd_sub,
   input  logic              cfg_two_ch,
   output logic              ch0_valid,
   input  logic              ch0_ready,
   output logic [DATA_W-1:0] ch0_data,
   output logic [1:0]        ch0_tag,
   output logic              ch1_valid,
   input  logic              ch1_ready,
   output logic [DATA_W-1:0] ch1_data,
   output logic [1:0]        ch1_tag
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("stream_splitter: DATA_W must be at least 1");
      end
   endgenerate

   logic [POS_W-1:0] cur_pos;
   sub_tag_e         tag;
   logic             accept;

   assign accept = in_valid && in_ready;

   split_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (in_line_start),
      .advance (accept),
      .cur_pos (cur_pos)
   );

   split_route #(.ALLOW_SUBSPLIT(ALLOW_SUBSPLIT)) u_route (
      .in_valid    (in_valid),
      .cur_pos     (cur_pos),
      .cfg_split   (cfg_split),
      .cfg_odd_sub (cfg_odd_sub),
      .cfg_two_ch  (cfg_two_ch),
      .ch0_ready   (ch0_ready),
      .ch1_ready   (ch1_ready),
      .ch0_valid   (ch0_valid),
      .ch1_valid   (ch1_valid),
      .tag         (tag),
      .in_ready    (in_ready)
   );

   assign ch0_data = in_data;
   assign ch1_data = in_data;
   assign ch0_tag  = tag;
   assign ch1_tag  = tag;
endmodule

// File: rtl/stream_splitter_chk.sv
module stream_splitter_chk #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              in_line_start,
   input logic              cfg_split,
   input logic              cfg_two_ch,
   input logic              ch0_valid,
   input logic              ch0_ready,
   input logic [DATA_W-1:0] ch0_data,
   input logic [1:0]        ch0_tag,
   input logic              ch1_valid,
   input logic              ch1_ready,
   input logic [DATA_W-1:0] ch1_data,
   input logic [1:0]        ch1_tag
);
   p_pass_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_split && in_valid) |-> (ch0_valid && ch0_tag == 2'd0 && !ch1_valid));

   p_single_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_split && !cfg_two_ch) |-> !ch1_valid);

   p_ch1_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch1_valid |-> (ch1_tag != 2'd1 && ch1_tag != 2'd0));

   p_line_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_split && in_valid && in_line_start) |-> (ch0_valid && ch0_tag == 2'd1));

   p_ready_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch0_valid |-> (in_ready == ch0_ready));

   p_ready_follow1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ch1_valid |-> (in_ready == ch1_ready));

   p_one_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ch0_valid, ch1_valid}) <= 1);

   p_data_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ch0_valid |-> ch0_data == in_data) and (ch1_valid |-> ch1_data == in_data));

   p_valid_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!ch0_valid && !ch1_valid));
endmodule

bind stream_splitter stream_splitter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .in_data       (in_data),
   .in_line_start (in_line_start),
   .cfg_split     (cfg_split),
   .cfg_two_ch    (cfg_two_ch),
   .ch0_valid     (ch0_valid),
   .ch0_ready     (ch0_ready),
   .ch0_data      (ch0_data),
   .ch0_tag       (ch0_tag),
   .ch1_valid     (ch1_valid),
   .ch1_ready     (ch1_ready),
   .ch1_data      (ch1_data),
   .ch1_tag       (ch1_tag)
);

// File: tb/stream_splitter_tb_top.sv
module stream_splitter_tb_top;
   localparam int unsigned W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_ready, in_line_start = 1'b0;
   logic [W-1:0] in_data = '0;
   logic cfg_split = 1'b0, cfg_odd_sub = 1'b0, cfg_two_ch = 1'b0;
   logic ch0_valid, ch0_ready = 1'b1, ch1_valid, ch1_ready = 1'b1;
   logic [W-1:0] ch0_data, ch1_data;
   logic [1:0] ch0_tag, ch1_tag;

   int checks = 0;
   int fails = 0;
   logic [1:0] m_pos = 2'd0;
   bit first_after_reset = 1'b1;

   always #2 clk = ~clk;

   stream_splitter #(.DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_line_start(in_line_start), .cfg_split(cfg_split),
      .cfg_odd_sub(cfg_odd_sub), .cfg_two_ch(cfg_two_ch),
      .ch0_valid(ch0_valid), .ch0_ready(ch0_ready), .ch0_data(ch0_data), .ch0_tag(ch0_tag),
      .ch1_valid(ch1_valid), .ch1_ready(ch1_ready), .ch1_data(ch1_data), .ch1_tag(ch1_tag)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_tag(input logic [1:0] cur, input logic sp, input logic sub);
      if (!sp) return 2'd0;
      if (!cur[0]) return 2'd1;
      if (sub && cur[1]) return 2'd3;
      return 2'd2;
   endfunction

   task automatic step(input logic v, input logic ls, input logic r0, input logic r1, input logic [W-1:0] d);
      logic [1:0] cur, et;
      logic to1, erdy;
      string rq;
      @(negedge clk);
      in_valid = v; in_line_start = ls; ch0_ready = r0; ch1_ready = r1; in_data = d;
      #1;
      cur  = ls ? 2'd0 : m_pos;
      et   = exp_tag(cur, cfg_split, cfg_odd_sub);
      to1  = cfg_split && cfg_two_ch && et != 2'd1;
      erdy = to1 ? r1 : r0;
      if (!cfg_split) rq = (cfg_odd_sub || cfg_two_ch) ? "R9" : "R2";
      else if (ls) rq = "R7";
      else if (first_after_reset) rq = "R1";
      else if (cfg_odd_sub) rq = "R4";
      else rq = "R3";
      if (v) begin
         chk(ch0_valid == !to1 && ch1_valid == to1, cfg_two_ch ? "R5 channel" : "R6 channel",
             {ch0_valid, ch1_valid}, {!to1, to1});
         chk((to1 ? ch1_tag : ch0_tag) == et, rq, to1 ? ch1_tag : ch0_tag, et);
         chk((to1 ? ch1_data : ch0_data) == d, "R10 data", to1 ? ch1_data : ch0_data, d);
         chk(in_ready == erdy, "R8 ready", in_ready, erdy);
         if (erdy) begin
            m_pos = cur + 2'd1;
            first_after_reset = 1'b0;
         end
      end else begin
         chk(!ch0_valid && !ch1_valid, "R1 idle", {ch0_valid, ch1_valid}, 0);
      end
   endtask

   task automatic set_cfg(input logic sp, input logic sub, input logic two);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_split = sp; cfg_odd_sub = sub; cfg_two_ch = two;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      // reset state, R1
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk(!ch0_valid && !ch1_valid, "R1 reset", {ch0_valid, ch1_valid}, 0);
      @(negedge clk); rst_n = 1'b1;
      // R1 first sample even, then R3 alternation on single channel (R6)
      set_cfg(1, 0, 0);
      for (int i = 0; i < 6; i++) step(1, 0, 1, 1, W'(16'h100 + i));
      // R4 subsplit pattern, two channels (R5)
      set_cfg(1, 1, 1);
      step(1, 1, 1, 1, 16'hA000);
      for (int i = 0; i < 8; i++) step(1, 0, 1, 1, W'(16'hA001 + i));
      // R8 stall on odd target then release; stall held with line start (R7)
      step(1, 0, 1, 0, 16'hBEEF);
      step(1, 0, 1, 0, 16'hBEEF);
      step(1, 0, 1, 1, 16'hBEEF);
      step(1, 1, 0, 1, 16'hC0DE);
      step(1, 1, 1, 1, 16'hC0DE);
      // R2 / R9 pass-through with other settings set
      set_cfg(0, 1, 1);
      for (int i = 0; i < 4; i++) step(1, i == 2, 1, 0, W'(16'hFFFF - i));
      set_cfg(0, 0, 0);
      step(1, 0, 1, 1, 16'h0000);
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         if (i % 200 == 0) set_cfg($urandom_range(0, 5) != 0, 1'($urandom), 1'($urandom));
         step($urandom_range(0, 3) != 0, $urandom_range(0, 9) == 0,
              $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, W'($urandom));
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule